// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

A register-programmed raster engine that moves or paints rectangles of 32-bit words inside a linear video memory. Software loads the geometry through a small write-only register port. That geometry is the source and destination byte offsets, the pitches, the x/y positions, the width and height, a pixel-format code, a raster-op code and a brush colour. A single-cycle start then launches one operation. The engine owns the memory port for the whole operation. It reports its state through `busy` and a one-cycle `done`, and it leaves three sticky error flags behind.

Each operation is checked as a whole before it touches memory. The check decodes the raster-op code, derives word strides from the pitches and tests the rectangle against the memory size. The engine then walks the rectangle one word at a time in raster order: two memory cycles per word for a copy, one for a fill. Fill colours come from a byte-swapped brush or from a six-entry palette of bytes. When the operation succeeds, the destination position registers advance so that the next operation can follow on from where this one ended.

Top module: `blit_engine`

## Requirements
- R1: The low 4 bits of the format register give the pixel depth: code 2 is 8, codes 3 and 4 are 16, code 5 is 24, code 6 is 32. Any other code gives depth 0 and sets status bit 0 (bad format), and the operation still runs.
- R2: Bits [7:0] of the raster-op register select the operation: 0xCC copy, 0xF0 pattern fill, 0x00 black fill, 0xFF white fill. Any other value sets status bit 1 and writes no memory, and the destination position stays unchanged.
- R3: Pattern fill writes the brush register with its four bytes in reverse order.
- R4: Palette writes (register 13) take the entry index from bits [10:8] and the byte from bits [7:0]. Black fill writes {pal0, pal1, pal2, 0xFF} and white fill writes {pal3, pal4, pal5, 0xFF}, with the first entry in bits [31:24].
- R5: When mode bit 0 is clear, stride in words is pitch/4. When it is set, stride is pitch×depth/4, and the display base (register 14, masked to 27 bits) is added to both the source and the destination byte offsets.
- R6: The operation aborts with status bit 2 and no memory write if either of two tests fails on the destination, or on the source for a copy. The tests are: the base byte address is at least 4×MEM_WORDS, or base + x + (y+height)×stride×4 is at least 4×MEM_WORDS.
- R7: Word (r,c) of the rectangle is at address base/4 + (y+r)×stride + x + c. Words are visited row by row from the top, and left to right within a row. A copy reads the source word in one cycle and writes it in the next.
- R8: A completed copy adds width to destination x and height to destination y. A completed fill adds only height to destination y. An aborted or rejected operation changes neither.
- R9: `busy` rises on the clock that accepts start. `done` is high for exactly one cycle, and `busy` falls after it. Start is ignored while busy. Latency from start to done is 2 + 2·W·H cycles for a copy, 2 + W·H for a fill and 2 for a rejected or aborted operation.
- R10: The status flags are sticky and are cleared by the next accepted start.
- R11: A width or height of zero writes no memory, still completes, and advances the position as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| start | input | 1 | Start pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Sticky flags: [0] bad format, [1] unknown op, [2] out of range |
| dst_x_pos | output | 16 | Current destination x register |
| dst_y_pos | output | 16 | Current destination y register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | log2(MEM_WORDS) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |

## Verification
The bench attacks the abort paths, with an unknown op and with both a source and a destination rectangle just past the end of memory. A design that checked too late or checked the wrong side would leave partial writes, or would advance the position anyway. It runs pixel-pitch mode at two depths with a display base that has high bits set, so a missing mask or a depth decode error moves every write address. A second start pulse mid-copy, a zero-width fill and a bad format code are used. Each would show up as a doubled done, extra writes, a lost position advance or a missing flag.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int COORD_W = 16;
    localparam int WORD_W  = 32;
    localparam int OFF_W   = 32;
    localparam int BASE_W  = 27;
    localparam int PAL_N   = 6;
    localparam int PAL_IW  = 3;

    localparam logic [7:0] ROP_COPY  = 8'hCC;
    localparam logic [7:0] ROP_PAT   = 8'hF0;
    localparam logic [7:0] ROP_BLACK = 8'h00;
    localparam logic [7:0] ROP_WHITE = 8'hFF;

    localparam int FLAG_FMT = 0;
    localparam int FLAG_OP  = 1;
    localparam int FLAG_RNG = 2;

    localparam logic [3:0] RA_SRC_OFF = 4'd0;
    localparam logic [3:0] RA_DST_OFF = 4'd1;
    localparam logic [3:0] RA_SRC_PIT = 4'd2;
    localparam logic [3:0] RA_DST_PIT = 4'd3;
    localparam logic [3:0] RA_SRC_X   = 4'd4;
    localparam logic [3:0] RA_SRC_Y   = 4'd5;
    localparam logic [3:0] RA_DST_X   = 4'd6;
    localparam logic [3:0] RA_DST_Y   = 4'd7;
    localparam logic [3:0] RA_WIDTH   = 4'd8;
    localparam logic [3:0] RA_HEIGHT  = 4'd9;
    localparam logic [3:0] RA_FORMAT  = 4'd10;
    localparam logic [3:0] RA_ROP     = 4'd11;
    localparam logic [3:0] RA_BRUSH   = 4'd12;
    localparam logic [3:0] RA_PAL     = 4'd13;
    localparam logic [3:0] RA_BASE    = 4'd14;
    localparam logic [3:0] RA_MODE    = 4'd15;

    typedef enum logic [2:0] {
        OP_COPY, OP_PAT, OP_BLACK, OP_WHITE, OP_NONE
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_READ, S_WRITE, S_FILL, S_FIN
    } walk_state_e;

    typedef struct packed {
        logic [OFF_W-1:0]   src_off;
        logic [OFF_W-1:0]   dst_off;
        logic [COORD_W-1:0] src_pitch;
        logic [COORD_W-1:0] dst_pitch;
        logic [COORD_W-1:0] src_x;
        logic [COORD_W-1:0] src_y;
        logic [COORD_W-1:0] dst_x;
        logic [COORD_W-1:0] dst_y;
        logic [COORD_W-1:0] width;
        logic [COORD_W-1:0] height;
        logic [3:0]         format;
        logic [7:0]         rop;
        logic [WORD_W-1:0]  brush;
        logic [BASE_W-1:0]  disp_base;
        logic               pix_mode;
    } blit_cfg_t;

    function automatic logic [5:0] depth_of(input logic [3:0] code);
        case (code)
            4'd2:        return 6'd8;
            4'd3, 4'd4:  return 6'd16;
            4'd5:        return 6'd24;
            4'd6:        return 6'd32;
            default:     return 6'd0;
        endcase
    endfunction

    function automatic op_kind_e op_of(input logic [7:0] code);
        case (code)
            ROP_COPY:  return OP_COPY;
            ROP_PAT:   return OP_PAT;
            ROP_BLACK: return OP_BLACK;
            ROP_WHITE: return OP_WHITE;
            default:   return OP_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/blit_palette.sv
module blit_palette import blit_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PAL_IW-1:0] idx,
    input  logic [7:0]        val,
    output logic [WORD_W-1:0] black_colour,
    output logic [WORD_W-1:0] white_colour
);
    logic [7:0] entry_q [PAL_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAL_N; i++) entry_q[i] <= '0;
        end else if (we && (int'(idx) < PAL_N)) begin
            entry_q[idx] <= val;
        end
    end

    assign black_colour = {entry_q[0], entry_q[1], entry_q[2], 8'hFF};
    assign white_colour = {entry_q[3], entry_q[4], entry_q[5], 8'hFF};
endmodule

// File: rtl/blit_geom.sv
module blit_geom import blit_pkg::*; #(
    parameter int MEM_WORDS = 1024
) (
    input  logic [OFF_W-1:0]   src_off,
    input  logic [OFF_W-1:0]   dst_off,
    input  logic [COORD_W-1:0] src_pitch,
    input  logic [COORD_W-1:0] dst_pitch,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] height,
    input  logic [3:0]         format,
    input  logic [BASE_W-1:0]  disp_base,
    input  logic               pix_mode,
    input  logic               need_src,
    output logic [31:0]        src_stride,
    output logic [31:0]        dst_stride,
    output logic [31:0]        src_row0,
    output logic [31:0]        dst_row0,
    output logic               fmt_bad,
    output logic               range_bad
);
    localparam logic [63:0] END_BYTES = 64'(MEM_WORDS) * 64'd4;

    logic [5:0]  depth;
    logic [31:0] src_pe, dst_pe, src_base, dst_base, base_add;
    logic [63:0] src_lim, dst_lim;
    logic        src_bad, dst_bad;

    assign depth    = depth_of(format);
    assign fmt_bad  = (depth == 6'd0);
    assign base_add = pix_mode ? 32'(disp_base) : 32'd0;
    assign src_pe   = pix_mode ? 32'(src_pitch) * 32'(depth) : 32'(src_pitch);
    assign dst_pe   = pix_mode ? 32'(dst_pitch) * 32'(depth) : 32'(dst_pitch);
    assign src_stride = src_pe >> 2;
    assign dst_stride = dst_pe >> 2;
    assign src_base = src_off + base_add;
    assign dst_base = dst_off + base_add;

    assign src_lim = 64'(src_base) + 64'(src_x)
                   + (64'(src_y) + 64'(height)) * 64'(src_stride) * 64'd4;
    assign dst_lim = 64'(dst_base) + 64'(dst_x)
                   + (64'(dst_y) + 64'(height)) * 64'(dst_stride) * 64'd4;

    assign src_bad   = (64'(src_base) >= END_BYTES) || (src_lim >= END_BYTES);
    assign dst_bad   = (64'(dst_base) >= END_BYTES) || (dst_lim >= END_BYTES);
    assign range_bad = dst_bad || (need_src && src_bad);

    assign src_row0 = (src_base >> 2) + 32'(src_y) * src_stride + 32'(src_x);
    assign dst_row0 = (dst_base >> 2) + 32'(dst_y) * dst_stride + 32'(dst_x);
endmodule

// File: rtl/blit_walker.sv
module blit_walker import blit_pkg::*; #(
    parameter int AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  op_kind_e           op,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    input  logic [31:0]        src_stride,
    input  logic [31:0]        dst_stride,
    input  logic [31:0]        src_row0,
    input  logic [31:0]        dst_row0,
    input  logic               fmt_bad,
    input  logic               range_bad,
    input  logic [WORD_W-1:0]  pat_colour,
    input  logic [WORD_W-1:0]  black_colour,
    input  logic [WORD_W-1:0]  white_colour,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               busy,
    output logic               done,
    output logic [2:0]         status,
    output logic               adv_copy,
    output logic               adv_fill
);
    walk_state_e        state_q;
    logic [COORD_W-1:0] col_q, row_q;
    logic [31:0]        srow_q, drow_q;
    logic [WORD_W-1:0]  fill_q;
    logic [2:0]         flags_q;
    logic               last_col, last_word, empty, step, finish_ok;

    assign last_col  = (col_q == width - 16'd1);
    assign last_word = last_col && (row_q == height - 16'd1);
    assign empty     = (width == '0) || (height == '0);
    assign step      = (state_q == S_WRITE) || (state_q == S_FILL);
    assign finish_ok = (state_q == S_SETUP && op != OP_NONE && !range_bad && empty)
                     || (step && last_word);
    assign adv_copy  = finish_ok && (op == OP_COPY);
    assign adv_fill  = finish_ok && (op != OP_COPY) && (op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            col_q   <= '0;
            row_q   <= '0;
            srow_q  <= '0;
            drow_q  <= '0;
            fill_q  <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    flags_q <= '0;
                    state_q <= S_SETUP;
                end
                S_SETUP: begin
                    if (op == OP_NONE) begin
                        flags_q[FLAG_OP] <= 1'b1;
                        state_q <= S_FIN;
                    end else begin
                        flags_q[FLAG_FMT] <= fmt_bad;
                        if (range_bad) begin
                            flags_q[FLAG_RNG] <= 1'b1;
                            state_q <= S_FIN;
                        end else if (empty) begin
                            state_q <= S_FIN;
                        end else begin
                            col_q   <= '0;
                            row_q   <= '0;
                            srow_q  <= src_row0;
                            drow_q  <= dst_row0;
                            fill_q  <= (op == OP_PAT)   ? pat_colour :
                                       (op == OP_BLACK) ? black_colour : white_colour;
                            state_q <= (op == OP_COPY) ? S_READ : S_FILL;
                        end
                    end
                end
                S_READ: state_q <= S_WRITE;
                S_WRITE, S_FILL: begin
                    if (last_word) begin
                        state_q <= S_FIN;
                    end else begin
                        if (last_col) begin
                            col_q  <= '0;
                            row_q  <= row_q + 16'd1;
                            srow_q <= srow_q + src_stride;
                            drow_q <= drow_q + dst_stride;
                        end else begin
                            col_q <= col_q + 16'd1;
                        end
                        if (state_q == S_WRITE) state_q <= S_READ;
                    end
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign mem_en    = (state_q == S_READ) || step;
    assign mem_we    = step;
    assign mem_addr  = AW'(((state_q == S_READ) ? srow_q : drow_q) + 32'(col_q));
    assign mem_wdata = (state_q == S_WRITE) ? mem_rdata : fill_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FIN);
    assign status    = flags_q;

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_releases_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !done) |=> busy);
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && status == 3'b000));
endmodule

// File: rtl/blit_engine.sv
module blit_engine import blit_pkg::*; #(
    parameter int MEM_WORDS = 1024,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [2:0]         status,
    output logic [COORD_W-1:0] dst_x_pos,
    output logic [COORD_W-1:0] dst_y_pos,
    output logic               mem_en,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata
);
    blit_cfg_t         cfg_q;
    op_kind_e          op;
    logic [31:0]       src_stride, dst_stride, src_row0, dst_row0;
    logic              fmt_bad, range_bad, adv_copy, adv_fill;
    logic [WORD_W-1:0] black_colour, white_colour;

    assign op = op_of(cfg_q.rop);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RA_SRC_OFF: cfg_q.src_off   <= reg_wdata;
                    RA_DST_OFF: cfg_q.dst_off   <= reg_wdata;
                    RA_SRC_PIT: cfg_q.src_pitch <= reg_wdata[COORD_W-1:0];
                    RA_DST_PIT: cfg_q.dst_pitch <= reg_wdata[COORD_W-1:0];
                    RA_SRC_X:   cfg_q.src_x     <= reg_wdata[COORD_W-1:0];
                    RA_SRC_Y:   cfg_q.src_y     <= reg_wdata[COORD_W-1:0];
                    RA_DST_X:   cfg_q.dst_x     <= reg_wdata[COORD_W-1:0];
                    RA_DST_Y:   cfg_q.dst_y     <= reg_wdata[COORD_W-1:0];
                    RA_WIDTH:   cfg_q.width     <= reg_wdata[COORD_W-1:0];
                    RA_HEIGHT:  cfg_q.height    <= reg_wdata[COORD_W-1:0];
                    RA_FORMAT:  cfg_q.format    <= reg_wdata[3:0];
                    RA_ROP:     cfg_q.rop       <= reg_wdata[7:0];
                    RA_BRUSH:   cfg_q.brush     <= reg_wdata;
                    RA_BASE:    cfg_q.disp_base <= reg_wdata[BASE_W-1:0];
                    RA_MODE:    cfg_q.pix_mode  <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (adv_copy) cfg_q.dst_x <= cfg_q.dst_x + cfg_q.width;
            if (adv_copy || adv_fill) cfg_q.dst_y <= cfg_q.dst_y + cfg_q.height;
        end
    end

    blit_palette u_pal (
        .clk          (clk),
        .rst          (rst),
        .we           (reg_we && reg_addr == RA_PAL),
        .idx          (reg_wdata[8+PAL_IW-1:8]),
        .val          (reg_wdata[7:0]),
        .black_colour (black_colour),
        .white_colour (white_colour)
    );

    blit_geom #(.MEM_WORDS(MEM_WORDS)) u_geom (
        .src_off    (cfg_q.src_off),
        .dst_off    (cfg_q.dst_off),
        .src_pitch  (cfg_q.src_pitch),
        .dst_pitch  (cfg_q.dst_pitch),
        .src_x      (cfg_q.src_x),
        .src_y      (cfg_q.src_y),
        .dst_x      (cfg_q.dst_x),
        .dst_y      (cfg_q.dst_y),
        .height     (cfg_q.height),
        .format     (cfg_q.format),
        .disp_base  (cfg_q.disp_base),
        .pix_mode   (cfg_q.pix_mode),
        .need_src   (op == OP_COPY),
        .src_stride (src_stride),
        .dst_stride (dst_stride),
        .src_row0   (src_row0),
        .dst_row0   (dst_row0),
        .fmt_bad    (fmt_bad),
        .range_bad  (range_bad)
    );

    blit_walker #(.AW(AW)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .op           (op),
        .width        (cfg_q.width),
        .height       (cfg_q.height),
        .src_stride   (src_stride),
        .dst_stride   (dst_stride),
        .src_row0     (src_row0),
        .dst_row0     (dst_row0),
        .fmt_bad      (fmt_bad),
        .range_bad    (range_bad),
        .pat_colour   (swap_bytes(cfg_q.brush)),
        .black_colour (black_colour),
        .white_colour (white_colour),
        .mem_rdata    (mem_rdata),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .busy         (busy),
        .done         (done),
        .status       (status),
        .adv_copy     (adv_copy),
        .adv_fill     (adv_fill)
    );

    assign dst_x_pos = cfg_q.dst_x;
    assign dst_y_pos = cfg_q.dst_y;

    assert_no_write_bad_op_R2: assert property (@(posedge clk) disable iff (rst)
        status[FLAG_OP] |-> !mem_we);
    assert_no_write_out_of_range_R6: assert property (@(posedge clk) disable iff (rst)
        status[FLAG_RNG] |-> !mem_we);
    assert_write_only_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);
endmodule

// File: tb/blit_engine_tb_top.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
    localparam int MW = 256;
    localparam longint ENDB = MW * 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        start = 1'b0;
    logic        busy, done, mem_en, mem_we;
    logic [2:0]  status;
    logic [15:0] dst_x_pos, dst_y_pos;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [MW];
    logic [31:0] exp_mem [MW];
    logic [39:0] wr_q [$];

    longint s_soff, s_doff, s_sp, s_dp, s_sx, s_sy, s_dx, s_dy, s_w, s_h;
    longint s_fmt, s_rop, s_brush, s_disp, s_mode;
    logic [7:0] pal [6];

    always #4 clk = ~clk;

    blit_engine #(.MEM_WORDS(MW)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .start(start), .busy(busy), .done(done),
        .status(status), .dst_x_pos(dst_x_pos), .dst_y_pos(dst_y_pos),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] seed_word(int i);
        return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'(i * 7);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MW; i++) mem[i] <= seed_word(i);
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // per-clock comparison of every memory write against the model queue (R7)
    always @(negedge clk) begin
        if (!rst && mem_en && mem_we) begin
            if (wr_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected write addr", longint'(mem_addr), 0);
            end else begin
                logic [39:0] e;
                e = wr_q.pop_front();
                chk(mem_addr == e[39:32], "R7", "write address", longint'(mem_addr), longint'(e[39:32]));
                chk(mem_wdata == e[31:0], "R7", "write data", longint'(mem_wdata), longint'(e[31:0]));
            end
        end
    end

    task automatic wr(input logic [3:0] a, input longint d);
        reg_addr  = a;
        reg_wdata = 32'(d);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        case (a)
            4'd0: s_soff = d;  4'd1: s_doff = d;
            4'd2: s_sp = d;    4'd3: s_dp = d;
            4'd4: s_sx = d;    4'd5: s_sy = d;
            4'd6: s_dx = d;    4'd7: s_dy = d;
            4'd8: s_w = d;     4'd9: s_h = d;
            4'd10: s_fmt = d & 15;  4'd11: s_rop = d & 255;
            4'd12: s_brush = d;     4'd13: pal[(d >> 8) & 7] = 8'(d);
            4'd14: s_disp = d;      4'd15: s_mode = d & 1;
            default: ;
        endcase
    endtask

    function automatic longint bpp_of(longint code);
        if (code == 2) return 8;
        if (code == 3 || code == 4) return 16;
        if (code == 5) return 24;
        if (code == 6) return 32;
        return 0;
    endfunction

    task automatic run_op(input string req, input bit extra_start);
        longint d, disp, ss, ds, sb, db, lat_exp, nx, ny;
        int     kind;
        bit     oob;
        logic [2:0]  st_exp;
        logic [31:0] colour;
        int     lat, bad;
        d = bpp_of(s_fmt);
        case (s_rop)
            8'hCC: kind = 0;
            8'hF0: kind = 1;
            8'h00: kind = 2;
            8'hFF: kind = 3;
            default: kind = 4;
        endcase
        st_exp = 3'b000; lat_exp = 2; nx = s_dx; ny = s_dy;
        colour = (kind == 1) ? {s_brush[7:0], s_brush[15:8], s_brush[23:16], s_brush[31:24]} :
                 (kind == 2) ? {pal[0], pal[1], pal[2], 8'hFF} : {pal[3], pal[4], pal[5], 8'hFF};
        if (kind == 4) begin
            st_exp[1] = 1'b1;
        end else begin
            if (d == 0) st_exp[0] = 1'b1;
            disp = s_mode ? (s_disp & 64'h07FFFFFF) : 0;
            ss = (s_mode ? s_sp * d : s_sp) / 4;
            ds = (s_mode ? s_dp * d : s_dp) / 4;
            sb = s_soff + disp;
            db = s_doff + disp;
            oob = (db >= ENDB) || (db + s_dx + (s_dy + s_h) * ds * 4 >= ENDB);
            if (kind == 0)
                oob = oob || (sb >= ENDB) || (sb + s_sx + (s_sy + s_h) * ss * 4 >= ENDB);
            if (oob) begin
                st_exp[2] = 1'b1;
            end else begin
                for (longint r = 0; r < s_h; r++) begin
                    for (longint c = 0; c < s_w; c++) begin
                        longint da, sa;
                        logic [31:0] v;
                        da = ((db / 4) + (s_dy + r) * ds + s_dx + c) % MW;
                        sa = ((sb / 4) + (s_sy + r) * ss + s_sx + c) % MW;
                        v  = (kind == 0) ? exp_mem[sa] : colour;
                        wr_q.push_back({8'(da), v});
                        exp_mem[da] = v;
                    end
                end
                lat_exp = 2 + ((kind == 0) ? 2 : 1) * s_w * s_h;
                if (kind == 0) nx = (s_dx + s_w) & 16'hFFFF;
                ny = (s_dy + s_h) & 16'hFFFF;
            end
        end
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R9", {req, " busy after start"}, longint'(busy), 1);
        while (!done && lat < 4000) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            start = (extra_start && lat == 3);
        end
        start = 1'b0;
        chk(lat == lat_exp, "R9", {req, " latency"}, lat, lat_exp);
        chk(status == st_exp, req, "status", longint'(status), longint'(st_exp));
        chk(dst_x_pos == 16'(nx), "R8", {req, " dst x"}, longint'(dst_x_pos), nx);
        chk(dst_y_pos == 16'(ny), "R8", {req, " dst y"}, longint'(dst_y_pos), ny);
        s_dx = nx; s_dy = ny;
        @(negedge clk);
        chk(!done && !busy, "R9", {req, " done one cycle then idle"}, longint'({done, busy}), 0);
        chk(wr_q.size() == 0, req, "missing writes", wr_q.size(), 0);
        wr_q.delete();
        bad = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, "memory words differing", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) exp_mem[i] = seed_word(i);
        for (int i = 0; i < 6; i++) pal[i] = 8'h00;
        s_soff = 0; s_doff = 0; s_sp = 0; s_dp = 0; s_sx = 0; s_sy = 0;
        s_dx = 0; s_dy = 0; s_w = 0; s_h = 0; s_fmt = 0; s_rop = 0;
        s_brush = 0; s_disp = 0; s_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_en, "R9", "reset idle", longint'({busy, done, mem_en}), 0);
        chk(status == 3'b000, "R10", "reset status", longint'(status), 0);

        // R7 R8: copy, byte pitch, 32 bpp
        wr(10, 6); wr(15, 0);
        wr(0, 0);   wr(2, 32); wr(4, 1); wr(5, 1);
        wr(1, 512); wr(3, 32); wr(6, 2); wr(7, 0);
        wr(8, 3);   wr(9, 2);  wr(11, 8'hCC);
        run_op("R7 copy", 1'b0);

        // R3: pattern fill from byte-reversed brush, continues from advanced position
        wr(12, 32'h11223344); wr(8, 2); wr(9, 3); wr(11, 8'hF0);
        run_op("R3 pattern", 1'b0);

        // R4: palette colours
        wr(13, 32'h010); wr(13, 32'h120); wr(13, 32'h230);
        wr(13, 32'h340); wr(13, 32'h450); wr(13, 32'h560);
        wr(6, 1); wr(8, 1); wr(9, 1); wr(11, 8'h00);
        run_op("R4 black", 1'b0);
        wr(6, 0); wr(8, 3); wr(11, 8'hFF);
        run_op("R4 white", 1'b0);

        // R2: unknown op
        wr(11, 8'h66);
        run_op("R2 unknown op", 1'b0);

        // R6 R10: destination out of range, flags from previous op cleared
        wr(11, 8'hF0); wr(1, 1020); wr(7, 0); wr(9, 1);
        run_op("R6 dst range", 1'b0);
        // R6: source base past end for copy
        wr(1, 0); wr(0, 2000); wr(11, 8'hCC);
        run_op("R6 src range", 1'b0);

        // R1: unsupported format flags but still fills
        wr(0, 0); wr(10, 7); wr(1, 768); wr(6, 0); wr(7, 0);
        wr(8, 2); wr(9, 2); wr(11, 8'h00);
        run_op("R1 bad format", 1'b0);

        // R5 R1: pixel pitch mode, 8 bpp, masked display base
        wr(15, 1); wr(10, 2); wr(14, 32'hF8000040);
        wr(1, 256); wr(3, 4); wr(6, 0); wr(7, 0); wr(8, 2); wr(9, 2); wr(11, 8'hF0);
        run_op("R5 pixel 8bpp", 1'b0);
        // R5 R1: pixel mode 16 bpp copy (code 4), source also offset
        wr(10, 4); wr(0, 0); wr(2, 2); wr(4, 0); wr(5, 0);
        wr(1, 448); wr(3, 2); wr(6, 1); wr(7, 0); wr(8, 3); wr(9, 2); wr(11, 8'hCC);
        run_op("R5 pixel 16bpp", 1'b0);
        wr(15, 0); wr(10, 6);

        // R9: start ignored while busy
        wr(0, 64); wr(2, 32); wr(4, 0); wr(5, 0);
        wr(1, 640); wr(3, 32); wr(6, 0); wr(7, 0); wr(8, 4); wr(9, 2); wr(11, 8'hCC);
        run_op("R9 restart ignored", 1'b1);
        repeat (4) begin
            @(negedge clk);
            chk(!done && !busy, "R9", "no second op", longint'({done, busy}), 0);
        end

        // R11: zero width fill
        wr(8, 0); wr(9, 3); wr(11, 8'hFF);
        run_op("R11 zero width", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule